// File: doc/BRIEF.md
# Wake and SMI Event Router

This block gathers power-management events for a peripheral controller and turns them into two active-low group signals. Eight general-purpose wake lines feed a wake (PME) path, and seven per-function interrupt requests (watchdog, two group interrupts, floppy, two UARTs, parallel port) feed a system-management (SMI) path. Every event input passes through a two-flop synchronizer. The synchronized value is always readable as status, whatever the enable settings are.

Software reaches the block through a small synchronous byte port. The port holds a per-line wake enable register, a global wake enable, a per-source SMI enable register, and an SMI control register. The SMI control register has a master gate for the SMI pin and a redirect bit. The redirect bit makes the group SMI condition also count as a wake event. Status bits follow their inputs and cannot be cleared by a write. A source clears its status by dropping its request.

Register offsets: 0 wake status (read-only), 1 wake enable, 2 SMI status (read-only), 3 SMI source enable, 4 SMI control, 5 wake control. Offsets 6 and 7 read as zero.

Top module: `pm_event_router`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 00h and both pme_n and smi_n are high.
- R2: Offset 1 is a read/write wake enable register. Bit i qualifies wake_in[i], and it reads back exactly as written.
- R3: Offset 0 returns wake_in after the two-flop synchronizer, for any enable setting. Writes to offset 0 have no effect.
- R4: pme_n is low when bit 0 of offset 5 (global wake enable) is 1 and some wake_in[i] is high with wake-enable bit i set. The value on the inputs is seen within three clock edges.
- R5: A wake line whose enable bit is 0, or any wake line while the global wake enable is 0, leaves pme_n high.
- R6: Offset 2 returns the synchronized smi_req. Bit 7 is the watchdog, bit 6 group 1, bit 5 group 2, bit 4 floppy, bit 3 UART1, bit 2 UART2, bit 1 parallel port. Bit 0 always reads 0. Writes do not clear status.
- R7: The group SMI condition is the OR of smi_req[7:1] masked by the offset 3 enables. Offset 3 bit 0 is not stored and reads 0. smi_n is low exactly when the group condition is true and offset 4 bit 7 is 1.
- R8: When offset 4 bit 6 is 1 and the global wake enable is 1, a true group SMI condition drives pme_n low. This happens whether or not offset 4 bit 7 is set.
- R9: Offset 4 stores only bits 7 and 6, and offset 5 stores only bit 0. All other bits of these registers read 0, and offsets 6 and 7 read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_in | input | 8 | Asynchronous wake event lines |
| smi_req | input | 8 | Asynchronous SMI requests, bit 0 unused |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, sampled at clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pme_n | output | 1 | Active-low group wake output |
| smi_n | output | 1 | Active-low group SMI output |

## Verification
The only state in this block is the enables and the synchronizer stages. A wrong enable bit is visible on the next read of its offset. It also shows in pme_n or smi_n for the input pattern that bit qualifies, at most three edges after that pattern arrives. The sweeps therefore walk every wake pattern and every SMI pattern under several enable masks and control settings, and compare both outputs and the status reads after each pattern. A stuck synchronizer stage appears as status that lags or never follows the input. A write that reaches a status offset appears as status differing from the driven input.

// File: rtl/pm_evt_pkg.sv
// Package: shared widths, register offsets and control bit positions
// for the wake/SMI event router. Assumes a byte-wide register port.
package pm_evt_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam logic [AW-1:0] OFS_WAKE_STS = 3'd0;
    localparam logic [AW-1:0] OFS_WAKE_EN  = 3'd1;
    localparam logic [AW-1:0] OFS_SMI_STS  = 3'd2;
    localparam logic [AW-1:0] OFS_SMI_EN   = 3'd3;
    localparam logic [AW-1:0] OFS_SMI_CTL  = 3'd4;
    localparam logic [AW-1:0] OFS_WAKE_CTL = 3'd5;
    localparam int SMI_MASTER_BIT = 7;
    localparam int SMI_ROUTE_BIT  = 6;
    localparam int WAKE_GLOBAL_BIT = 0;
    localparam logic [DW-1:0] SMI_SRC_MASK = 8'hFE;
    localparam logic [DW-1:0] SMI_CTL_MASK = 8'hC0;
endpackage

// File: rtl/pm_evt_sync.sv
// Module: multi-stage flop synchronizer for a bus of independent
// level signals. Assumes each bit is a slow level (no bus coherency).
module pm_evt_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift one synchronizer stage per clock, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage[s] <= '0;
            else if (s == 0)
                stage[s] <= d;
            else
                stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pm_evt_regs.sv
// Module: register file of the event router. Holds the enables and
// control bits and muxes read data. Assumes status comes in already
// synchronized; status offsets ignore writes.
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] wake_sts,
    input  logic [DW-1:0] smi_sts,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] wake_en,
    output logic [DW-1:0] smi_en,
    output logic [DW-1:0] smi_ctl,
    output logic          wake_global
);
    // Update the writable registers on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en     <= '0;
            smi_en      <= '0;
            smi_ctl     <= '0;
            wake_global <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_WAKE_EN:  wake_en     <= reg_wdata;
                OFS_SMI_EN:   smi_en      <= reg_wdata & SMI_SRC_MASK;
                OFS_SMI_CTL:  smi_ctl     <= reg_wdata & SMI_CTL_MASK;
                OFS_WAKE_CTL: wake_global <= reg_wdata[WAKE_GLOBAL_BIT];
                default: ;
            endcase
        end
    end

    // Select read data for the addressed offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_WAKE_STS: reg_rdata = wake_sts;
            OFS_WAKE_EN:  reg_rdata = wake_en;
            OFS_SMI_STS:  reg_rdata = smi_sts & SMI_SRC_MASK;
            OFS_SMI_EN:   reg_rdata = smi_en;
            OFS_SMI_CTL:  reg_rdata = smi_ctl;
            OFS_WAKE_CTL: reg_rdata[WAKE_GLOBAL_BIT] = wake_global;
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pm_evt_combine.sv
// Module: output combiner. Forms the group SMI condition and both
// active-low outputs from synchronized events and registered enables.
// Purely combinational; assumes bit 0 of the SMI bus is reserved.
module pm_evt_combine
    import pm_evt_pkg::*;
(
    input  logic [DW-1:0] wake_sts,
    input  logic [DW-1:0] smi_sts,
    input  logic [DW-1:0] wake_en,
    input  logic [DW-1:0] smi_en,
    input  logic [DW-1:0] smi_ctl,
    input  logic          wake_global,
    output logic          pme_n,
    output logic          smi_n
);
    logic group_smi;
    logic wake_any;

    // Reduce enabled sources and gate them onto the two outputs.
    always_comb begin
        group_smi = |(smi_sts & smi_en & SMI_SRC_MASK);
        wake_any  = |(wake_sts & wake_en);
        pme_n = ~(wake_global & (wake_any | (smi_ctl[SMI_ROUTE_BIT] & group_smi)));
        smi_n = ~(smi_ctl[SMI_MASTER_BIT] & group_smi);
    end
endmodule

// File: rtl/pm_event_router.sv
// Module: top of the wake/SMI event router. Synchronizes the event
// buses, holds the register file and drives pme_n and smi_n.
// Assumes the register port is synchronous to clk.
module pm_event_router
    import pm_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wake_in,
    input  logic [DW-1:0] smi_req,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          pme_n,
    output logic          smi_n
);
    logic [DW-1:0] wake_sync, smi_sync;
    logic [DW-1:0] wake_en, smi_en, smi_ctl;
    logic          wake_global;

    pm_evt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_wake_sync (
        .clk(clk), .rst_n(rst_n), .d(wake_in), .q(wake_sync));

    pm_evt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_smi_sync (
        .clk(clk), .rst_n(rst_n), .d(smi_req), .q(smi_sync));

    pm_evt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .wake_sts(wake_sync), .smi_sts(smi_sync),
        .reg_rdata(reg_rdata), .wake_en(wake_en), .smi_en(smi_en),
        .smi_ctl(smi_ctl), .wake_global(wake_global));

    pm_evt_combine u_combine (
        .wake_sts(wake_sync), .smi_sts(smi_sync), .wake_en(wake_en),
        .smi_en(smi_en), .smi_ctl(smi_ctl), .wake_global(wake_global),
        .pme_n(pme_n), .smi_n(smi_n));
endmodule

// File: rtl/pm_event_router_chk.sv
// Module: property checker for pm_event_router, attached by bind.
// Observes ports and the registered enables and synchronizer outputs.
module pm_event_router_chk
    import pm_evt_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_rdata,
    input logic [DW-1:0] wake_sync,
    input logic [DW-1:0] smi_sync,
    input logic [DW-1:0] wake_en,
    input logic [DW-1:0] smi_en,
    input logic [DW-1:0] smi_ctl,
    input logic          wake_global,
    input logic          pme_n,
    input logic          smi_n
);
    // R1: reset clears every enable and control register.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (wake_en == '0 && smi_en == '0 && smi_ctl == '0 && !wake_global));

    // R3: the wake status read shows the synchronizer output.
    assert_wake_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_WAKE_STS) |-> (reg_rdata == wake_sync));

    // R4: an enabled active wake line with global enable pulls pme_n low.
    assert_wake_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_global && |(wake_sync & wake_en)) |-> !pme_n);

    // R5: without the global wake enable pme_n stays high.
    assert_wake_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_global |-> pme_n);

    // R6: reserved SMI status bit always reads 0.
    assert_smi_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_SMI_STS) |-> !reg_rdata[0]);

    // R7: SMI pin stays high while the master gate is off.
    assert_smi_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_ctl[SMI_MASTER_BIT] |-> smi_n);

    // R8: with redirect and global enable, an asserted SMI pin implies pme_n low.
    assert_smi_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_global && smi_ctl[SMI_ROUTE_BIT] && !smi_n) |-> !pme_n);
endmodule

bind pm_event_router pm_event_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .wake_sync(wake_sync), .smi_sync(smi_sync), .wake_en(wake_en),
    .smi_en(smi_en), .smi_ctl(smi_ctl), .wake_global(wake_global),
    .pme_n(pme_n), .smi_n(smi_n));

// File: tb/tb_pm_event_router.sv
// Bench: sweeps every wake and SMI pattern under several enable and
// control settings; expected outputs are computed from the requirements.
module tb_pm_event_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wake_in = '0;
    logic [7:0] smi_req = '0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pme_n, smi_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pm_event_router dut (
        .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .smi_req(smi_req),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pme_n(pme_n), .smi_n(smi_n));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #2;
        check(req, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] wen_set [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
        logic [7:0] sen_set [4] = '{8'hFE, 8'h00, 8'h56, 8'h81};
        logic [7:0] ctl_set [4] = '{8'h00, 8'h80, 8'h40, 8'hC0};
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) rd_check("R1 reg", 3'(a), 8'h00);
        check("R1 pme_n", {7'd0, pme_n}, 8'h01);
        check("R1 smi_n", {7'd0, smi_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: wake enable readback
        wr(3'd1, 8'h5A); rd_check("R2 wake_en", 3'd1, 8'h5A);
        wr(3'd1, 8'hC3); rd_check("R2 wake_en", 3'd1, 8'hC3);
        // R9: storage masks and unmapped offsets
        wr(3'd3, 8'hFF); rd_check("R7 smi_en bit0", 3'd3, 8'hFE);
        wr(3'd4, 8'hFF); rd_check("R9 smi_ctl", 3'd4, 8'hC0);
        wr(3'd5, 8'hFF); rd_check("R9 wake_ctl", 3'd5, 8'h01);
        wr(3'd6, 8'hFF); rd_check("R9 ofs6", 3'd6, 8'h00);
        wr(3'd7, 8'hFF); rd_check("R9 ofs7", 3'd7, 8'h00);
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);

        // R3/R4/R5: wake sweep
        for (int g = 0; g < 2; g++) begin
            wr(3'd5, 8'(g));
            for (int e = 0; e < 4; e++) begin
                wr(3'd1, wen_set[e]);
                for (int w = 0; w < 256; w++) begin
                    wake_in = 8'(w);
                    settle();
                    check("R4/R5 pme_n", {7'd0, pme_n},
                          {7'd0, !((g == 1) && ((8'(w) & wen_set[e]) != 0))});
                    rd_check("R3 wake status", 3'd0, 8'(w));
                end
            end
        end
        wake_in = 8'h96; settle();
        wr(3'd0, 8'h00); rd_check("R3 write ignored", 3'd0, 8'h96);
        wake_in = 8'h00; settle();

        // R6/R7/R8: SMI sweep with global wake enable on
        wr(3'd5, 8'h01); wr(3'd1, 8'hFF);
        for (int c = 0; c < 4; c++) begin
            wr(3'd4, ctl_set[c]);
            for (int e = 0; e < 4; e++) begin
                wr(3'd3, sen_set[e]);
                for (int s = 0; s < 256; s++) begin
                    logic grp;
                    smi_req = 8'(s);
                    settle();
                    grp = ((8'(s) & sen_set[e] & 8'hFE) != 0);
                    check("R7 smi_n", {7'd0, smi_n}, {7'd0, !(grp && ctl_set[c][7])});
                    check("R8 pme_n", {7'd0, pme_n}, {7'd0, !(grp && ctl_set[c][6])});
                    rd_check("R6 smi status", 3'd2, 8'(s) & 8'hFE);
                end
            end
        end
        smi_req = 8'hFF; settle();
        wr(3'd2, 8'h00); rd_check("R6 write no clear", 3'd2, 8'hFE);
        // R8 with global wake enable off: redirect has no effect
        wr(3'd4, 8'hC0); wr(3'd3, 8'hFE); wr(3'd5, 8'h00); settle();
        check("R8 gated pme_n", {7'd0, pme_n}, 8'h01);
        check("R7 smi_n on", {7'd0, smi_n}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule